// File: doc/BRIEF.md
# Paired-Word Load/Store Execution Unit

This unit carries out the two instructions that move a pair of consecutive 32-bit words between memory and an even/odd register pair. A decoded instruction word is presented together with a `start` pulse. The unit names three register-file read ports: base, offset and data pair. It samples their values in the start cycle and checks the encoding for illegal combinations. It then forms an effective address from the base and an offset, which is either an 8-bit immediate or a register. The offset is added or subtracted.

A legal, aligned request runs two word transactions over a request/ready memory handshake, at the effective address and then 4 bytes above it. On completion the unit pulses `done` for one cycle. In that same cycle it presents every register-file write: the loaded pair for a load, and the updated base when the addressing mode asks for one. An illegal encoding raises the undefined flag and a misaligned address raises the alignment flag. A memory abort raises the fault flag. In all three cases nothing is written back.

Top module: `pair_xfer_unit`

## Requirements
- R1: Instruction bits [7:4] pick the operation: 4'hD is a pair load and 4'hE is a pair store. Any other value finishes with `undef_flag` set, issues no memory request and performs no write.
- R2: When bit 22 is 1 the offset is the zero-extended 8-bit value {instr[11:8], instr[3:0]}. When bit 22 is 0 the offset is the register named by instr[3:0], read through `rd_ofs_idx`. Bit 23 set adds the offset to the base, and bit 23 clear subtracts it.
- R3: Bit 21 (writeback) set with bit 24 (pre-index) clear finishes with `undef_flag`, and there is no memory request and no write.
- R4: The data register index is instr[15:12] and the base index is instr[19:16]. An odd data index is undefined. For a load, data index 14 is undefined. For a store, base index 15 is undefined.
- R5: The effective address is base±offset when bit 24 is 1, and the unmodified base when bit 24 is 0.
- R6: If the low 3 bits of the effective address are not all zero, the unit finishes with `align_flag` and issues no memory request. This check ranks below R1, R3 and R4 and above R7, and the two flags are never set together.
- R7: When bit 24 is 0 or bit 21 is 1, a base index equal to the data index or to the data index plus one is undefined.
- R8: The first beat uses the effective address and the even register. The second beat uses the effective address plus 4 and the odd register. Each request, with its address and write data, is held until `mem_ready` is seen.
- R9: A beat accepted with `mem_abort` ends the sequence with `fault_flag`. No further beat is issued, and neither the pair nor the base is written.
- R10: On success the unit writes the base in the `done` cycle, together with the loaded pair for a load. The base receives base±offset when bit 24 is 0 or bit 21 is 1. Otherwise the base is not written.
- R11: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after start until `done` ends, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution of `instr` (accepted only when idle) |
| instr | input | 32 | Decoded instruction word |
| rd_base_idx | output | 4 | Read index of the base register |
| rd_ofs_idx | output | 4 | Read index of the offset register |
| rd_even_idx | output | 4 | Read index of the even data register |
| rd_odd_idx | output | 4 | Read index of the odd data register |
| rf_base | input | XLEN | Base register value |
| rf_ofs | input | XLEN | Offset register value |
| rf_even | input | XLEN | Even data register value |
| rf_odd | input | XLEN | Odd data register value |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | XLEN | Beat byte address |
| mem_wdata | output | XLEN | Beat write data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_abort | input | 1 | Accepted beat aborted (valid with ready) |
| mem_rdata | input | XLEN | Read data (valid with ready) |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Undefined encoding (with done) |
| align_flag | output | 1 | Misaligned effective address (with done) |
| fault_flag | output | 1 | Memory abort occurred (with done) |
| wr_pair_en | output | 1 | Write loaded pair |
| wr_pair_idx | output | 4 | Even register index of the pair |
| wr_even_data | output | XLEN | First loaded word |
| wr_odd_data | output | XLEN | Second loaded word |
| wr_base_en | output | 1 | Write updated base |
| wr_base_idx | output | 4 | Base register index |
| wr_base_data | output | XLEN | Updated base value |

## Verification
The pair write and the base writeback of a load share the single `done` cycle. The bench provokes this by sweeping every combination of the four mode bits with register indices chosen to collide or not. In that cycle it judges both enables and both payloads against values computed from a snapshot of its register model. The sweep also lands overlap and misalignment on the same instruction, and the bench then judges which flag wins. Aborts are placed on either beat under varying ready stalls to confirm that the commit cycle carries no write.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_FIN   = 2'd3
    } pxu_state_e;

    localparam logic [3:0] OP_LOAD_PAIR  = 4'hD;
    localparam logic [3:0] OP_STORE_PAIR = 4'hE;
    localparam int BIT_WB  = 21;
    localparam int BIT_IMM = 22;
    localparam int BIT_UP  = 23;
    localparam int BIT_PRE = 24;
    localparam logic [3:0] IDX_LINK = 4'd14;
    localparam logic [3:0] IDX_PC   = 4'd15;
endpackage

// File: rtl/pxu_decode.sv
module pxu_decode
    import pxu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ALIGN_W = 3
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] ofs_val,
    output logic            is_load,
    output logic            undef,
    output logic            align_fault,
    output logic            wb_en,
    output logic [XLEN-1:0] eff_addr,
    output logic [XLEN-1:0] wb_addr
);
    logic [3:0]      op;
    logic            is_store, f_wb, f_imm, f_up, f_pre;
    logic [3:0]      bidx, didx;
    logic [XLEN-1:0] ofs, sum;
    logic            early_undef, misal, overlap;
    logic            unused_instr_bits;

    assign unused_instr_bits = &{1'b0, instr[31:25], instr[20]};

    always_comb begin
        op       = instr[7:4];
        is_load  = (op == OP_LOAD_PAIR);
        is_store = (op == OP_STORE_PAIR);
        f_wb     = instr[BIT_WB];
        f_imm    = instr[BIT_IMM];
        f_up     = instr[BIT_UP];
        f_pre    = instr[BIT_PRE];
        bidx     = instr[19:16];
        didx     = instr[15:12];

        ofs      = f_imm ? {{(XLEN-8){1'b0}}, instr[11:8], instr[3:0]} : ofs_val;
        sum      = f_up ? (base_val + ofs) : (base_val - ofs);
        eff_addr = f_pre ? sum : base_val;
        wb_addr  = sum;
        wb_en    = !f_pre || f_wb;

        early_undef = !(is_load || is_store)
                    || (f_wb && !f_pre)
                    || didx[0]
                    || (is_load && didx == IDX_LINK)
                    || (is_store && bidx == IDX_PC);
        misal   = |eff_addr[ALIGN_W-1:0];
        overlap = wb_en && (bidx == didx || bidx == {didx[3:1], 1'b1});

        undef       = early_undef || (!misal && overlap);
        align_fault = !early_undef && misal;
    end
endmodule

// File: rtl/pxu_seq.sv
module pxu_seq
    import pxu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int ALIGN_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dec_load,
    input  logic            dec_undef,
    input  logic            dec_align,
    input  logic            dec_wb,
    input  logic [XLEN-1:0] dec_ea,
    input  logic [XLEN-1:0] dec_wb_addr,
    input  logic [3:0]      base_idx,
    input  logic [3:0]      even_idx,
    input  logic [XLEN-1:0] rf_even,
    input  logic [XLEN-1:0] rf_odd,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ready,
    input  logic            mem_abort,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            undef_flag,
    output logic            align_flag,
    output logic            fault_flag,
    output logic            wr_pair_en,
    output logic [3:0]      wr_pair_idx,
    output logic [XLEN-1:0] wr_even_data,
    output logic [XLEN-1:0] wr_odd_data,
    output logic            wr_base_en,
    output logic [3:0]      wr_base_idx,
    output logic [XLEN-1:0] wr_base_data
);
    typedef struct packed {
        pxu_state_e      st;
        logic            ld;
        logic            wb;
        logic            undef;
        logic            align;
        logic            fault;
        logic [3:0]      bidx;
        logic [3:0]      didx;
        logic [XLEN-1:0] ea;
        logic [XLEN-1:0] wbv;
        logic [XLEN-1:0] w0;
        logic [XLEN-1:0] w1;
        logic [XLEN-1:0] r0;
        logic [XLEN-1:0] r1;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ok_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: if (start) begin
                seq_d.ld    = dec_load;
                seq_d.wb    = dec_wb;
                seq_d.undef = dec_undef;
                seq_d.align = dec_align;
                seq_d.fault = 1'b0;
                seq_d.bidx  = base_idx;
                seq_d.didx  = even_idx;
                seq_d.ea    = dec_ea;
                seq_d.wbv   = dec_wb_addr;
                seq_d.w0    = rf_even;
                seq_d.w1    = rf_odd;
                seq_d.st    = (dec_undef || dec_align) ? ST_FIN : ST_BEAT0;
            end
            ST_BEAT0: if (mem_ready) begin
                if (mem_abort) begin
                    seq_d.fault = 1'b1;
                    seq_d.st    = ST_FIN;
                end else begin
                    seq_d.r0 = mem_rdata;
                    seq_d.st = ST_BEAT1;
                end
            end
            ST_BEAT1: if (mem_ready) begin
                seq_d.fault = mem_abort;
                seq_d.r1    = mem_rdata;
                seq_d.st    = ST_FIN;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ok_q         = !seq_q.undef && !seq_q.align && !seq_q.fault;
    assign mem_req      = (seq_q.st == ST_BEAT0) || (seq_q.st == ST_BEAT1);
    assign mem_we       = !seq_q.ld;
    assign mem_addr     = (seq_q.st == ST_BEAT1) ? (seq_q.ea + WORD_BYTES) : seq_q.ea;
    assign mem_wdata    = (seq_q.st == ST_BEAT1) ? seq_q.w1 : seq_q.w0;
    assign busy         = (seq_q.st != ST_IDLE);
    assign done         = (seq_q.st == ST_FIN);
    assign undef_flag   = done && seq_q.undef;
    assign align_flag   = done && seq_q.align;
    assign fault_flag   = done && seq_q.fault;
    assign wr_pair_en   = done && ok_q && seq_q.ld;
    assign wr_pair_idx  = seq_q.didx;
    assign wr_even_data = seq_q.r0;
    assign wr_odd_data  = seq_q.r1;
    assign wr_base_en   = done && ok_q && seq_q.wb;
    assign wr_base_idx  = seq_q.bidx;
    assign wr_base_data = seq_q.wbv;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_second_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BEAT0 && mem_ready && !mem_abort) |=> (mem_req && mem_addr == $past(mem_addr) + WORD_BYTES));

    assert_aligned_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BEAT0) |-> (mem_addr[ALIGN_W-1:0] == '0));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(undef_flag && align_flag));

    assert_abort_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_abort) |=> (done && !wr_pair_en && !wr_base_en && !mem_req));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flag_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (dec_undef || dec_align)) |=> (done && !mem_req));
endmodule

// File: rtl/pair_xfer_unit.sv
module pair_xfer_unit
    import pxu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    output logic [3:0]      rd_base_idx,
    output logic [3:0]      rd_ofs_idx,
    output logic [3:0]      rd_even_idx,
    output logic [3:0]      rd_odd_idx,
    input  logic [XLEN-1:0] rf_base,
    input  logic [XLEN-1:0] rf_ofs,
    input  logic [XLEN-1:0] rf_even,
    input  logic [XLEN-1:0] rf_odd,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ready,
    input  logic            mem_abort,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            undef_flag,
    output logic            align_flag,
    output logic            fault_flag,
    output logic            wr_pair_en,
    output logic [3:0]      wr_pair_idx,
    output logic [XLEN-1:0] wr_even_data,
    output logic [XLEN-1:0] wr_odd_data,
    output logic            wr_base_en,
    output logic [3:0]      wr_base_idx,
    output logic [XLEN-1:0] wr_base_data
);
    localparam int WORD_BYTES = XLEN / 8;
    localparam int ALIGN_W    = $clog2(2 * WORD_BYTES);

    logic            dec_load, dec_undef, dec_align, dec_wb;
    logic [XLEN-1:0] dec_ea, dec_wb_addr;

    assign rd_base_idx = instr[19:16];
    assign rd_ofs_idx  = instr[3:0];
    assign rd_even_idx = instr[15:12];
    assign rd_odd_idx  = {instr[15:13], 1'b1};

    pxu_decode #(.XLEN(XLEN), .ALIGN_W(ALIGN_W)) i_decode (
        .instr       (instr),
        .base_val    (rf_base),
        .ofs_val     (rf_ofs),
        .is_load     (dec_load),
        .undef       (dec_undef),
        .align_fault (dec_align),
        .wb_en       (dec_wb),
        .eff_addr    (dec_ea),
        .wb_addr     (dec_wb_addr)
    );

    pxu_seq #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES), .ALIGN_W(ALIGN_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dec_load     (dec_load),
        .dec_undef    (dec_undef),
        .dec_align    (dec_align),
        .dec_wb       (dec_wb),
        .dec_ea       (dec_ea),
        .dec_wb_addr  (dec_wb_addr),
        .base_idx     (rd_base_idx),
        .even_idx     (rd_even_idx),
        .rf_even      (rf_even),
        .rf_odd       (rf_odd),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_abort    (mem_abort),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .undef_flag   (undef_flag),
        .align_flag   (align_flag),
        .fault_flag   (fault_flag),
        .wr_pair_en   (wr_pair_en),
        .wr_pair_idx  (wr_pair_idx),
        .wr_even_data (wr_even_data),
        .wr_odd_data  (wr_odd_data),
        .wr_base_en   (wr_base_en),
        .wr_base_idx  (wr_base_idx),
        .wr_base_data (wr_base_data)
    );
endmodule

// File: tb/test_pair_xfer_unit.sv
module test_pair_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [31:0] instr;
    logic [3:0]  rd_base_idx, rd_ofs_idx, rd_even_idx, rd_odd_idx;
    logic [31:0] rf_base, rf_ofs, rf_even, rf_odd;
    logic        mem_req, mem_we, mem_ready, mem_abort;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, undef_flag, align_flag, fault_flag;
    logic        wr_pair_en, wr_base_en;
    logic [3:0]  wr_pair_idx, wr_base_idx;
    logic [31:0] wr_even_data, wr_odd_data, wr_base_data;

    logic [31:0] regs [16];
    logic [31:0] memarr [64];
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign rf_base   = regs[rd_base_idx];
    assign rf_ofs    = regs[rd_ofs_idx];
    assign rf_even   = regs[rd_even_idx];
    assign rf_odd    = regs[rd_odd_idx];
    assign mem_rdata = memarr[mem_addr[7:2]];

    pair_xfer_unit #(.XLEN(32)) i_pair_xfer_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rd_base_idx(rd_base_idx), .rd_ofs_idx(rd_ofs_idx),
        .rd_even_idx(rd_even_idx), .rd_odd_idx(rd_odd_idx),
        .rf_base(rf_base), .rf_ofs(rf_ofs), .rf_even(rf_even), .rf_odd(rf_odd),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_abort(mem_abort), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .undef_flag(undef_flag), .align_flag(align_flag),
        .fault_flag(fault_flag), .wr_pair_en(wr_pair_en), .wr_pair_idx(wr_pair_idx),
        .wr_even_data(wr_even_data), .wr_odd_data(wr_odd_data),
        .wr_base_en(wr_base_en), .wr_base_idx(wr_base_idx), .wr_base_data(wr_base_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic init_state(input logic [3:0] b, input logic [31:0] basev);
        for (int k = 0; k < 16; k++) regs[k] = 32'hC0DE_0000 + 32'(k) * 32'h0011;
        regs[4] = 32'h34;
        regs[8] = 32'h20;
        regs[b] = basev;
    endtask

    task automatic run_op(input logic [31:0] ins, input int stall,
                          input int abort_beat, input bit glitch);
        logic        ld, st, w, im, u, p, e_undef0, e_mis, wbk, ovl, e_undef, e_align, legal, e_fault;
        logic [3:0]  b, d;
        logic [31:0] base, ofs, sum, ea, v0, v1, s0, s1;
        logic [31:0] ba [2];
        logic [31:0] bd [2];
        logic        bw [2];
        int          beats, waitc, e_beats;
        bit          got;
        ld = (ins[7:4] == 4'hD); st = (ins[7:4] == 4'hE);
        w = ins[21]; im = ins[22]; u = ins[23]; p = ins[24];
        b = ins[19:16]; d = ins[15:12];
        base = regs[b];
        ofs  = im ? {24'h0, ins[11:8], ins[3:0]} : regs[ins[3:0]];
        sum  = u ? base + ofs : base - ofs;
        ea   = p ? sum : base;
        e_undef0 = !(ld || st) || (w && !p) || d[0] || (ld && d == 4'd14) || (st && b == 4'd15);
        e_mis    = (ea[2:0] != 3'd0);
        wbk      = !p || w;
        ovl      = wbk && (b == d || b == (d | 4'd1));
        e_undef  = e_undef0 || (!e_mis && ovl);
        e_align  = !e_undef0 && e_mis;
        legal    = !e_undef && !e_align;
        e_fault  = legal && abort_beat < 2;
        e_beats  = !legal ? 0 : (abort_beat == 0 ? 1 : 2);
        v0 = memarr[ea[7:2]]; v1 = memarr[(ea[7:2] + 6'd1)];
        s0 = regs[d]; s1 = regs[d | 4'd1];
        ba[0] = 0; ba[1] = 0; bd[0] = 0; bd[1] = 0; bw[0] = 0; bw[1] = 0;

        @(negedge clk); instr = ins; start = 1'b1;
        @(negedge clk); start = 1'b0;
        beats = 0; waitc = 0; got = 0;
        for (int cyc = 0; cyc < 40 && !got; cyc++) begin
            mem_ready = 1'b0; mem_abort = 1'b0;
            if (glitch && cyc == 0 && !done) begin start = 1'b1; instr = 32'hFFFF_FFFF; end
            else begin start = 1'b0; instr = ins; end
            if (cyc == 0 && !done) chk(busy == 1'b1, "R11", "busy while running", 32'(busy), 1);
            if (done) begin
                got = 1;
                chk(undef_flag == e_undef, "R1 R3 R4 R7", "undef_flag", 32'(undef_flag), 32'(e_undef));
                chk(align_flag == e_align, "R6", "align_flag", 32'(align_flag), 32'(e_align));
                chk(fault_flag == e_fault, "R9", "fault_flag", 32'(fault_flag), 32'(e_fault));
                chk(beats == e_beats, "R8", "beat count", 32'(beats), 32'(e_beats));
                if (e_beats > 0) begin
                    chk(ba[0] == ea, "R5 R8", "beat0 addr", ba[0], ea);
                    chk(bw[0] == st, "R8", "beat0 we", 32'(bw[0]), 32'(st));
                    if (st) chk(bd[0] == s0, "R8", "beat0 wdata", bd[0], s0);
                end
                if (e_beats > 1) begin
                    chk(ba[1] == ea + 32'd4, "R8", "beat1 addr", ba[1], ea + 32'd4);
                    if (st) chk(bd[1] == s1, "R8", "beat1 wdata", bd[1], s1);
                end
                chk(wr_pair_en == (legal && !e_fault && ld), "R10", "pair write enable",
                    32'(wr_pair_en), 32'(legal && !e_fault && ld));
                if (legal && !e_fault && ld) begin
                    chk(wr_pair_idx == d, "R10", "pair index", 32'(wr_pair_idx), 32'(d));
                    chk(wr_even_data == v0 && wr_odd_data == v1, "R10", "pair data",
                        wr_odd_data ^ wr_even_data, v0 ^ v1);
                end
                chk(wr_base_en == (legal && !e_fault && wbk), "R10", "base write enable",
                    32'(wr_base_en), 32'(legal && !e_fault && wbk));
                if (legal && !e_fault && wbk) begin
                    chk(wr_base_idx == b, "R10", "base index", 32'(wr_base_idx), 32'(b));
                    chk(wr_base_data == sum, "R2 R10", "base value", wr_base_data, sum);
                end
            end else if (mem_req) begin
                if (waitc < stall) waitc++;
                else if (beats < 2) begin
                    mem_ready = 1'b1;
                    mem_abort = (beats == abort_beat);
                    ba[beats] = mem_addr; bd[beats] = mem_wdata; bw[beats] = mem_we;
                    if (mem_we && !mem_abort) memarr[mem_addr[7:2]] = mem_wdata;
                    beats++; waitc = 0;
                end
            end
            if (!got) @(negedge clk);
        end
        chk(got, "R11", "done seen", 32'(got), 1);
        mem_ready = 1'b0; mem_abort = 1'b0; start = 1'b0;
        @(negedge clk);
        chk(!done && !busy, "R11", "done single pulse / idle", {30'd0, done, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int opn;
        logic [31:0] ins;
        logic [3:0]  dsel [4];
        logic [3:0]  bsel [4];
        dsel[0] = 4'd0; dsel[1] = 4'd2; dsel[2] = 4'd3; dsel[3] = 4'd14;
        bsel[0] = 4'd2; bsel[1] = 4'd3; bsel[2] = 4'd9; bsel[3] = 4'd15;
        for (int k = 0; k < 64; k++) memarr[k] = 32'h5A00_0000 + 32'(k) * 32'h0101;
        for (int k = 0; k < 16; k++) regs[k] = 0;
        rst_n = 1'b0; start = 1'b0; instr = 0; mem_ready = 1'b0; mem_abort = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_req && !wr_pair_en && !wr_base_en, "R11", "reset state",
            {27'd0, done, busy, mem_req, wr_pair_en, wr_base_en}, 0);
        rst_n = 1'b1;
        opn = 0;
        // R1: operation selector values other than the two pair opcodes
        for (int k = 0; k < 4; k++) begin
            init_state(4'd9, 32'h100);
            ins = {7'd0, 4'b1100, 4'd9, 4'd2, 4'h1, 4'(k * 5 + 1), 4'd8};
            run_op(ins, 0, 2, 0);
        end
        // sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int ld = 0; ld < 2; ld++)
            for (int pw = 0; pw < 16; pw++)
                for (int di = 0; di < 4; di++)
                    for (int bi = 0; bi < 4; bi++)
                        for (int m = 0; m < 3; m++) begin
                            init_state(bsel[bi], (m == 1) ? 32'h104 : 32'h100);
                            ins = 32'd0;
                            ins[7:4]   = (ld != 0) ? 4'hD : 4'hE;
                            ins[24:21] = 4'(pw);
                            ins[19:16] = bsel[bi];
                            ins[15:12] = dsel[di];
                            ins[11:8]  = 4'h1;
                            ins[3:0]   = (m == 2) ? 4'd4 : 4'd8;
                            run_op(ins, opn % 3, (opn % 5 == 0) ? (opn / 5) % 2 : 2, (opn % 4) == 1);
                            opn++;
                        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule